// File: doc/BRIEF.md
# Bit I/O Port with Pattern-Test Flags

This block gives a processor core eight general-purpose pins, each of which can be an input or an output on its own. Software writes a direction byte to choose which pins drive. Output pins are changed by writing a command register. For each output pin, the command holds a two-bit operation: clear, set, hold or toggle. The same command bits have a different meaning for input pins. There they select which inputs are tested and the level each tested input should have.

Input pins pass through a synchronizer to the core clock. They are then reported in the value byte of the status register. Each command write compares the tested inputs with the pattern and records four condition flags: all-true, all-false, some-true and some-false. The conditional-execution logic of the core consumes these flags. Software can read the flags back and can write them to restore a saved state.

Every pin keeps its own output latch, whatever its direction. A pin that is turned into an input and later back into an output drives its old level again.

Top module: `gpio_bitport`

## Requirements
- R1: After a synchronous reset, all pins are inputs (pin_oe = 0), every output latch is 0 (pin_out = 0), the command register reads 0 and the flag register reads 4'b0011.
- R2: A write with wr_sel = 0 loads the direction byte from wr_data[15:8], where 1 means output. pin_oe equals that byte from the next cycle on. wr_data[7:0] of that write is ignored.
- R3: A write with wr_sel = 1 applies the operation {wr_data[8+n], wr_data[n]} to each output pin n: 00 clears, 01 sets, 10 holds, 11 toggles. pin_out shows the result in the cycle after the write. Without such a write, pin_out does not change.
- R4: A command write leaves the output latch of every input pin unchanged. A pin that goes from output to input and back to output drives its earlier level again.
- R5: A change on pin_in of an input pin shows in the value byte after the second rising clock edge, and not after the first.
- R6: On a command write, input pin n is tested when wr_data[8+n] = 1, against the expected level wr_data[n]. If every tested input matches, the flag register becomes 4'b0101. The bits are bit0 all-true, bit1 all-false, bit2 some-true and bit3 some-false.
- R7: If no tested input matches, the flags become 4'b1010. If some but not all match, they become 4'b1100.
- R8: If no input pin is tested, including the case where every pin is an output, a command write sets the flags to 4'b0011.
- R9: A write with wr_sel = 2 loads the flags from wr_data[3:0]. The flags change only on a command write or a flag write. Pin activity alone leaves them as they are.
- R10: When a direction write turns an output into an input, the value byte shows the pin's synchronized level in the next cycle. When a command write changes an output latch, the value byte shows it two cycles after the write.
- R11: rd_data is combinational. rd_sel = 0 gives {direction, value}, 1 gives the command register, 2 gives {12'b0, flags} and 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 status/direction, 1 command, 2 flags |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read target |
| rd_data | output | 16 | Read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output latch levels to the pads |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bound checker watches, on every cycle, how the pins follow the registers. It checks that pin_oe follows each direction write and that pin_out moves only on a command write. It also checks that input-pin latches survive command writes, that flag writes restore exactly what was written, that the flags never drift without a write, and that an all-output command gives the no-test code. The exact latency of the value byte, the synchronizer delay, the four match outcomes for chosen input patterns, and resuming an old level after a direction round trip all depend on sequences of stimulus. Only the bench scenarios can show these.

// File: rtl/gpio_bitport_pkg.sv
package gpio_bitport_pkg;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Packed so that bit 0 is all_true and bit 3 is some_false
    typedef struct packed {
        logic some_false;
        logic some_true;
        logic all_false;
        logic all_true;
    } cond_flags_t;

    localparam int unsigned FLAG_W = $bits(cond_flags_t);

    localparam cond_flags_t FLAGS_NOTEST = '{some_false: 1'b0, some_true: 1'b0,
                                             all_false: 1'b1, all_true: 1'b1};
    localparam cond_flags_t FLAGS_ALLHIT = '{some_false: 1'b0, some_true: 1'b1,
                                             all_false: 1'b0, all_true: 1'b1};
    localparam cond_flags_t FLAGS_NOHIT  = '{some_false: 1'b1, some_true: 1'b0,
                                             all_false: 1'b1, all_true: 1'b0};
    localparam cond_flags_t FLAGS_PART   = '{some_false: 1'b1, some_true: 1'b1,
                                             all_false: 1'b0, all_true: 1'b0};

    // Next level of one output latch for a {mode, data} operation
    function automatic logic drive_next(input logic cur, input logic mode, input logic data);
        logic nxt;
        case ({mode, data})
            2'b00:   nxt = 1'b0;
            2'b01:   nxt = 1'b1;
            2'b10:   nxt = cur;
            default: nxt = ~cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_bitport_sync.sv
module gpio_bitport_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bitport_drive.sv
module gpio_bitport_drive
    import gpio_bitport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_we,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] data,
    output logic [W-1:0] latch_q
);

    logic [W-1:0] latch_nxt;

    for (genvar i = 0; i < W; i++) begin : g_pin
        // Only output pins take the command; input pins keep their latch
        assign latch_nxt[i] = (cmd_we && dir[i]) ? drive_next(latch_q[i], mode[i], data[i])
                                                 : latch_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_nxt;
        end
    end

endmodule

// File: rtl/gpio_bitport_match.sv
module gpio_bitport_match
    import gpio_bitport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] level,
    output cond_flags_t  flags
);

    logic [W-1:0] tested;
    logic [W-1:0] hit;

    assign tested = ~dir & mask;
    assign hit    = tested & ~(level ^ pat);

    always_comb begin
        if (tested == '0) begin
            flags = FLAGS_NOTEST;
        end else if (hit == tested) begin
            flags = FLAGS_ALLHIT;
        end else if (hit == '0) begin
            flags = FLAGS_NOHIT;
        end else begin
            flags = FLAGS_PART;
        end
    end

endmodule

// File: rtl/gpio_bitport.sv
module gpio_bitport
    import gpio_bitport_pkg::*;
#(
    parameter int unsigned NPINS       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [2*NPINS-1:0] wr_data,
    input  logic [1:0]         rd_sel,
    output logic [2*NPINS-1:0] rd_data,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe
);

    localparam int unsigned REG_W = 2 * NPINS;

    reg_sel_e     wsel;
    reg_sel_e     rsel;
    logic         we_stat;
    logic         we_cmd;
    logic         we_flag;

    logic [NPINS-1:0] wr_hi;
    logic [NPINS-1:0] wr_lo;

    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] mode_q;
    logic [NPINS-1:0] data_q;
    cond_flags_t      flags_q;
    cond_flags_t      flags_eval;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] value_pipe_q;
    logic [NPINS-1:0] value_fld;

    assign wsel    = reg_sel_e'(wr_sel);
    assign rsel    = reg_sel_e'(rd_sel);
    assign we_stat = wr_en && (wsel == SEL_STAT);
    assign we_cmd  = wr_en && (wsel == SEL_CMD);
    assign we_flag = wr_en && (wsel == SEL_FLAG);
    assign wr_hi   = wr_data[REG_W-1:NPINS];
    assign wr_lo   = wr_data[NPINS-1:0];

    gpio_bitport_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_bitport_drive #(
        .W (NPINS)
    ) u_drive (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (we_cmd),
        .dir     (dir_q),
        .mode    (wr_hi),
        .data    (wr_lo),
        .latch_q (latch_q)
    );

    // Pattern test runs on the command being written and synchronized pins
    gpio_bitport_match #(
        .W (NPINS)
    ) u_match (
        .dir   (dir_q),
        .mask  (wr_hi),
        .pat   (wr_lo),
        .level (pin_sync),
        .flags (flags_eval)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            mode_q <= '0;
            data_q <= '0;
        end else begin
            if (we_stat) begin
                dir_q <= wr_hi;
            end
            if (we_cmd) begin
                mode_q <= wr_hi;
                data_q <= wr_lo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_NOTEST;
        end else if (we_cmd) begin
            flags_q <= flags_eval;
        end else if (we_flag) begin
            flags_q <= cond_flags_t'(wr_data[FLAG_W-1:0]);
        end
    end

    // One extra register on the output side gives the two-cycle value latency
    always_ff @(posedge clk) begin
        if (rst) begin
            value_pipe_q <= '0;
        end else begin
            value_pipe_q <= latch_q;
        end
    end

    assign value_fld = (dir_q & value_pipe_q) | (~dir_q & pin_sync);

    always_comb begin
        case (rsel)
            SEL_STAT: rd_data = {dir_q, value_fld};
            SEL_CMD:  rd_data = {mode_q, data_q};
            SEL_FLAG: rd_data = {{(REG_W-FLAG_W){1'b0}}, flags_q};
            default:  rd_data = '0;
        endcase
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_bitport_chk.sv
module gpio_bitport_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] dir_wdata,
    input logic [3:0]   flag_wdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [3:0]   flags
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0));

    // R2
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> (pin_oe == $past(dir_wdata)));

    // R3
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 2'd1) |=> $stable(pin_out));

    // R4
    input_latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

    // R8
    all_out_notest_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && pin_oe == '1) |=> (flags == 4'b0011));

    // R9
    flag_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2) |=> (flags == $past(flag_wdata)));

    // R9
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2)) |=> $stable(flags));

endmodule

bind gpio_bitport gpio_bitport_chk #(.W(NPINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .dir_wdata  (wr_data[2*NPINS-1:NPINS]),
    .flag_wdata (wr_data[3:0]),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .flags      (flags_q)
);

// File: tb/gpio_bitport_test.sv
`timescale 1ns/100ps
module gpio_bitport_test;

    localparam int KIND_RD  = 0;
    localparam int KIND_OUT = 1;
    localparam int KIND_OE  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic [7:0]  pin_in = 8'h00;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #4 clk = ~clk;

    gpio_bitport uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // Monitor: pops each expected item and compares against the ports
    initial begin
        forever begin
            item_t       it;
            logic [15:0] act;
            wait (sb.size() > 0);
            #0.2;
            it = sb.pop_front();
            case (it.kind)
                KIND_OUT: act = {8'h00, pin_out};
                KIND_OE:  act = {8'h00, pin_oe};
                default:  act = rd_data;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // Driver: pushes an expectation while holding the read select steady
    task automatic expect_item(input int kind, input logic [1:0] sel,
                               input logic [15:0] exp, input string tag);
        rd_sel = sel;
        sb.push_back('{kind: kind, exp: exp, tag: tag});
        #0.5;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (R1..R11 not completed): actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        expect_item(KIND_OE,  2'd0, 16'h0000, "R1 pin_oe");
        expect_item(KIND_OUT, 2'd0, 16'h0000, "R1 pin_out");
        expect_item(KIND_RD,  2'd1, 16'h0000, "R1 command");
        expect_item(KIND_RD,  2'd2, 16'h0003, "R1 flags");
        expect_item(KIND_RD,  2'd0, 16'h0000, "R1 R11 status");

        // R2 upper nibble outputs; low byte of the write ignored
        reg_write(2'd0, 16'hF0AB);
        expect_item(KIND_OE, 2'd0, 16'h00F0, "R2 pin_oe");
        expect_item(KIND_RD, 2'd0, 16'hF000, "R2 status low byte ignored");

        // R3 clear/set/hold/toggle on pins 4..7
        reg_write(2'd1, 16'hC0A0);
        expect_item(KIND_OUT, 2'd0, 16'h00A0, "R3 clear/set/hold/toggle");
        expect_item(KIND_RD,  2'd0, 16'hF000, "R10 value before two cycles");
        expect_item(KIND_RD,  2'd2, 16'h0003, "R8 no tested input");
        tick();
        expect_item(KIND_RD,  2'd0, 16'hF0A0, "R10 value two cycles after");
        reg_write(2'd1, 16'hF0F0);
        expect_item(KIND_OUT, 2'd0, 16'h0050, "R3 toggle all outputs");
        reg_write(2'd1, 16'hF000);
        expect_item(KIND_OUT, 2'd0, 16'h0050, "R3 hold all outputs");

        // R5 synchronizer delay
        tick();
        pin_in = 8'hF5;
        tick();
        expect_item(KIND_RD, 2'd0, 16'hF050, "R5 after one edge");
        tick();
        expect_item(KIND_RD, 2'd0, 16'hF055, "R5 after two edges");

        // R6 R7 R8 pattern tests on input pins 0..3 (levels 1,0,1,0)
        reg_write(2'd1, 16'hFF05);
        expect_item(KIND_RD,  2'd2, 16'h0005, "R6 all match");
        expect_item(KIND_OUT, 2'd0, 16'h0050, "R3 outputs held during test");
        reg_write(2'd1, 16'hFF0A);
        expect_item(KIND_RD,  2'd2, 16'h000A, "R7 none match");
        reg_write(2'd1, 16'hF303);
        expect_item(KIND_RD,  2'd2, 16'h000C, "R7 some match");
        reg_write(2'd1, 16'hF000);
        expect_item(KIND_RD,  2'd2, 16'h0003, "R8 mask clear");

        // R9 restore and persistence
        reg_write(2'd2, 16'hFFF6);
        expect_item(KIND_RD, 2'd2, 16'h0006, "R9 restore");
        pin_in = 8'h00;
        repeat (3) tick();
        expect_item(KIND_RD, 2'd2, 16'h0006, "R9 flags held across pin change");
        expect_item(KIND_RD, 2'd3, 16'h0000, "R11 unused select");

        // R8 every pin an output
        reg_write(2'd2, 16'h0005);
        reg_write(2'd0, 16'hFF00);
        expect_item(KIND_OE, 2'd0, 16'h00FF, "R2 all outputs");
        reg_write(2'd1, 16'hFF00);
        expect_item(KIND_RD,  2'd2, 16'h0003, "R8 all outputs");
        expect_item(KIND_OUT, 2'd0, 16'h0050, "R3 hold on all pins");

        // R4 R10 direction round trip on the upper pins
        reg_write(2'd0, 16'h0F00);
        expect_item(KIND_OE, 2'd0, 16'h000F, "R2 lower outputs");
        expect_item(KIND_RD, 2'd0, 16'h0F00, "R10 input value one cycle after direction write");
        reg_write(2'd1, 16'h0F0F);
        expect_item(KIND_OUT, 2'd0, 16'h005F, "R4 input latches kept");
        expect_item(KIND_RD,  2'd2, 16'h0003, "R8 upper mask clear");
        reg_write(2'd0, 16'hFF00);
        expect_item(KIND_OUT, 2'd0, 16'h005F, "R4 resume old level");
        expect_item(KIND_RD,  2'd0, 16'hFF5F, "R4 status after return");

        wait (sb.size() == 0);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule